// File: doc/BRIEF.md
# Configurable GPIO Port Register Cell

This block is one 8-bit general-purpose I/O port seen from a microcontroller's special-function-register bus. It keeps an output latch and three per-pin configuration registers: output drive (open-drain or push-pull), input mode (analog or digital) and crossbar skip. From these, and from a per-pin peripheral override, it computes the pad controls: a driven value and an output enable for each pin. Pad inputs are brought in through a two-flop synchronizer and can be read back on the bus.

A single register select chooses among the four registers for both reads and writes. Writes are either whole-byte or single-bit, where one bit changes and the rest are kept. Reads of the data register return the synchronized pin levels. When the bus marks the access as read-modify-write, the read returns the output latch instead, so the modify step of a bit-set, AND, OR, increment and similar operations works on the latch. One enable input places the two serial-bus pins, whose positions are parameters, in forced open-drain drive.

Top module: `gpio_port_cell`

## Requirements
- R1: After reset the data latch holds 0xFF, the output-mode register 0x00 (all open-drain), the input-mode register 0xFF (all digital) and the skip register 0x00.
- R2: A byte write (`wr_en`=1, `bit_mode`=0) stores `wr_data` into the register named by `reg_sel` (0 data latch, 1 output mode, 2 input mode, 3 skip), and the stored value is visible from the cycle after the write edge.
- R3: A single-bit write (`wr_en`=1, `bit_mode`=1) sets bit `bit_idx` of the selected register to `bit_val` and leaves every other bit unchanged.
- R4: A read with `reg_sel`=0 and `rmw`=0 returns the pin levels after two clock edges of synchronizer latency. This also holds for pins that a peripheral drives.
- R5: A read with `reg_sel`=0 and `rmw`=1 returns the output latch, not the pins.
- R6: For a digital pin, output-mode bit 0 selects open-drain: a drive value of 0 gives `pad_oe`=1 with `pad_out`=0, and a value of 1 gives `pad_oe`=0. Output-mode bit 1 selects push-pull: `pad_oe`=1 and `pad_out` equals the value.
- R7: A pin whose input-mode bit is 0 (analog) has `pad_oe`=0 and `pad_out`=0, and its bit in a pin read is 0.
- R8: While `sbus_en`=1, the pins at positions SDA_PIN (default 0) and SCL_PIN (default 1) are driven open-drain whatever their output-mode bits hold.
- R9: When `xbar_en` is 1 for a pin whose skip bit is 0, the drive value of that pin is `xbar_out` instead of the latch.
- R10: A pin whose skip bit is 1 ignores `xbar_en` and keeps driving from the latch.
- R11: Reads of the output-mode, input-mode and skip registers return their contents, whatever `rmw` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select for read and write (0 data, 1 output mode, 2 input mode, 3 skip) |
| wr_en | input | 1 | Write strobe |
| bit_mode | input | 1 | 1 selects a single-bit write |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| wr_data | input | 8 | Byte write data |
| rmw | input | 1 | Read is the read half of a read-modify-write |
| rd_data | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Output enable for each pad |
| xbar_en | input | 8 | Peripheral requests a pin's output |
| xbar_out | input | 8 | Peripheral output value per pin |
| sbus_en | input | 1 | Serial-bus pins forced to open-drain |

## Verification
The bench goes after the read source: a design that always returned pins would lose latched bits during read-modify-write, and one that always returned the latch would hide external levels. It probes the synchronizer edge by edge, which exposes a path with one stage or none, and the single-bit write, which would clobber neighbouring bits if it were handled as a byte write. Pad vectors set analog pins, skipped pins that have a peripheral request, and the forced open-drain serial pins against push-pull settings. A design that honoured the output-mode bit there, or let a skipped pin follow the peripheral, gives wrong `pad_oe` or `pad_out` bits.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register select codes shared by the bus decoder and the bench
    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_OMODE = 2'd1,
        SEL_IMODE = 2'd2,
        SEL_SKIP  = 2'd3
    } reg_sel_e;

    // Merge a byte or single-bit write into an existing register value
    function automatic logic [7:0] merge_write(
        input logic [7:0] old_val,
        input logic       bit_mode,
        input logic [7:0] mask,
        input logic       bit_val,
        input logic [7:0] byte_val
    );
        if (bit_mode)
            return (old_val & ~mask) | (bit_val ? mask : 8'h00);
        return byte_val;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int IDX_W       = $clog2(WIDTH),
    parameter logic [WIDTH-1:0] LATCH_RST = '1,
    parameter logic [WIDTH-1:0] OMODE_RST = '0,
    parameter logic [WIDTH-1:0] IMODE_RST = '1,
    parameter logic [WIDTH-1:0] SKIP_RST  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             bit_mode,
    input  logic [1:0]       reg_sel,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] omode_q,
    output logic [WIDTH-1:0] imode_q,
    output logic [WIDTH-1:0] skip_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] omode;
        logic [WIDTH-1:0] imode;
        logic [WIDTH-1:0] skip;
    } cfg_t;

    cfg_t             st_d, st_q;
    logic [WIDTH-1:0] bit_mask;

    function automatic logic [WIDTH-1:0] apply(input logic [WIDTH-1:0] old_val);
        if (bit_mode)
            return (old_val & ~bit_mask) | (bit_val ? bit_mask : '0);
        return wr_data;
    endfunction

    always_comb begin
        bit_mask = WIDTH'(1) << bit_idx;
        st_d     = st_q;
        if (wr_en) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_DATA:  st_d.latch = apply(st_q.latch);
                SEL_OMODE: st_d.omode = apply(st_q.omode);
                SEL_IMODE: st_d.imode = apply(st_q.imode);
                SEL_SKIP:  st_d.skip  = apply(st_q.skip);
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= LATCH_RST;
            st_q.omode <= OMODE_RST;
            st_q.imode <= IMODE_RST;
            st_q.skip  <= SKIP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.latch;
    assign omode_q = st_q.omode;
    assign imode_q = st_q.imode;
    assign skip_q  = st_q.skip;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH   = 8,
    parameter int SDA_PIN = 0,
    parameter int SCL_PIN = 1
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] omode,
    input  logic [WIDTH-1:0] imode,
    input  logic [WIDTH-1:0] skip,
    input  logic [WIDTH-1:0] xbar_en,
    input  logic [WIDTH-1:0] xbar_out,
    input  logic             sbus_en,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        localparam bit IS_SBUS = (i == SDA_PIN) || (i == SCL_PIN);

        logic owned;
        logic drv_val;
        logic open_drain;
        logic digital;

        always_comb begin
            digital    = imode[i];
            owned      = xbar_en[i] & ~skip[i];
            drv_val    = owned ? xbar_out[i] : latch[i];
            open_drain = ~omode[i] | (sbus_en & IS_SBUS);
            if (!digital) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
            end else if (open_drain) begin
                pad_oe[i]  = ~drv_val;
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = drv_val;
            end
        end
    end

endmodule

// File: rtl/gpio_port_cell.sv
module gpio_port_cell
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int SDA_PIN = 0,
    parameter int SCL_PIN = 1,
    localparam int IDX_W  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic             bit_mode,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] xbar_en,
    input  logic [WIDTH-1:0] xbar_out,
    input  logic             sbus_en
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] omode_q;
    logic [WIDTH-1:0] imode_q;
    logic [WIDTH-1:0] skip_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] pin_rd;

    gpio_cfg_regs #(
        .WIDTH (WIDTH),
        .IDX_W (IDX_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .bit_mode (bit_mode),
        .reg_sel  (reg_sel),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val),
        .wr_data  (wr_data),
        .latch_q  (latch_q),
        .omode_q  (omode_q),
        .imode_q  (imode_q),
        .skip_q   (skip_q)
    );

    gpio_in_sync #(
        .WIDTH  (WIDTH),
        .STAGES (2)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_pad_ctrl #(
        .WIDTH   (WIDTH),
        .SDA_PIN (SDA_PIN),
        .SCL_PIN (SCL_PIN)
    ) pads_i (
        .latch    (latch_q),
        .omode    (omode_q),
        .imode    (imode_q),
        .skip     (skip_q),
        .xbar_en  (xbar_en),
        .xbar_out (xbar_out),
        .sbus_en  (sbus_en),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // Analog pins read as zero on the digital path
    assign pin_rd = pin_sync & imode_q;

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_DATA:  rd_data = rmw ? latch_q : pin_rd;
            SEL_OMODE: rd_data = omode_q;
            SEL_IMODE: rd_data = imode_q;
            SEL_SKIP:  rd_data = skip_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_cell_chk.sv
module gpio_port_cell_chk #(
    parameter int WIDTH   = 8,
    parameter int SDA_PIN = 0,
    parameter int SCL_PIN = 1,
    parameter int IDX_W   = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             wr_en,
    input logic             bit_mode,
    input logic [IDX_W-1:0] bit_idx,
    input logic [WIDTH-1:0] wr_data,
    input logic             rmw,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic             sbus_en,
    input logic [WIDTH-1:0] latch,
    input logic [WIDTH-1:0] omode,
    input logic [WIDTH-1:0] imode
);

    logic [WIDTH-1:0] chk_mask;
    assign chk_mask = WIDTH'(1) << bit_idx;

    AST_BYTE_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bit_mode && reg_sel == 2'd0) |=> (latch == $past(wr_data))); // R2

    AST_BIT_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bit_mode && reg_sel == 2'd0) |=>
            ((latch & ~$past(chk_mask)) == ($past(latch) & ~$past(chk_mask)))); // R3

    AST_RMW_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw && reg_sel == 2'd0) |-> (rd_data == latch)); // R5

    AST_ANALOG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~imode) == '0) && ((pad_out & ~imode) == '0)); // R7

    AST_SBUS_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        sbus_en |-> (!pad_out[SDA_PIN] && !pad_out[SCL_PIN])); // R8

    for (genvar i = 0; i < WIDTH; i++) begin : g_pp
        localparam bit IS_SBUS = (i == SDA_PIN) || (i == SCL_PIN);
        AST_PUSH_PULL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (imode[i] && omode[i] && !(sbus_en && IS_SBUS)) |-> pad_oe[i]); // R6
    end

endmodule

bind gpio_port_cell gpio_port_cell_chk #(
    .WIDTH   (WIDTH),
    .SDA_PIN (SDA_PIN),
    .SCL_PIN (SCL_PIN),
    .IDX_W   (IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .bit_mode (bit_mode),
    .bit_idx  (bit_idx),
    .wr_data  (wr_data),
    .rmw      (rmw),
    .rd_data  (rd_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .sbus_en  (sbus_en),
    .latch    (latch_q),
    .omode    (omode_q),
    .imode    (imode_q)
);

// File: tb/gpio_port_cell_tb_top.sv
module gpio_port_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       bit_mode = 1'b0;
    logic [2:0] bit_idx = 3'd0;
    logic       bit_val = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rmw = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] xbar_en = 8'h00;
    logic [7:0] xbar_out = 8'h00;
    logic       sbus_en = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_port_cell dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .wr_en    (wr_en),
        .bit_mode (bit_mode),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val),
        .wr_data  (wr_data),
        .rmw      (rmw),
        .rd_data  (rd_data),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .xbar_en  (xbar_en),
        .xbar_out (xbar_out),
        .sbus_en  (sbus_en)
    );

    // Fields: latch, omode, imode, skip, xbar_en, xbar_out, sbus_en, exp_out, exp_oe
    localparam logic [64:0] VEC [8] = '{
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h05 ^ 8'h05}, // R6 open-drain released
        {8'h0F, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'hF0},         // R6 open-drain pulls low
        {8'hA5, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFF},         // R6 push-pull
        {8'hA5, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 8'h05, 8'h0F},         // R7 analog upper nibble
        {8'hA5, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 8'hA4, 8'hFE},         // R8 serial pins forced
        {8'h00, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'hF0, 1'b0, 8'hF0, 8'hFF},         // R9 peripheral override
        {8'h00, 8'hFF, 8'hFF, 8'h30, 8'hF0, 8'hF0, 1'b0, 8'hC0, 8'hFF},         // R10 skip ignores override
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h0A, 1'b0, 8'h00, 8'h05}          // R9 override in open-drain
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel  = sel;
        wr_en    = 1'b1;
        bit_mode = 1'b0;
        wr_data  = val;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic wr_bit(input logic [1:0] sel, input logic [2:0] idx, input logic val);
        @(negedge clk);
        reg_sel  = sel;
        wr_en    = 1'b1;
        bit_mode = 1'b1;
        bit_idx  = idx;
        bit_val  = val;
        @(negedge clk);
        wr_en    = 1'b0;
        bit_mode = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic is_rmw, output logic [7:0] val);
        reg_sel = sel;
        rmw     = is_rmw;
        #1;
        val     = rd_data;
        rmw     = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(2'd0, 1'b1, v); check("R1 latch reset", v, 8'hFF);
        rd(2'd1, 1'b0, v); check("R1 output mode reset", v, 8'h00);
        rd(2'd2, 1'b0, v); check("R1 input mode reset", v, 8'hFF);
        rd(2'd3, 1'b0, v); check("R1 skip reset", v, 8'h00);
        check("R1 pad_oe reset", pad_oe, 8'h00);

        // Pad control vectors
        for (int k = 0; k < 8; k++) begin
            wr_byte(2'd0, VEC[k][64:57]);
            wr_byte(2'd1, VEC[k][56:49]);
            wr_byte(2'd2, VEC[k][48:41]);
            wr_byte(2'd3, VEC[k][40:33]);
            xbar_en  = VEC[k][32:25];
            xbar_out = VEC[k][24:17];
            sbus_en  = VEC[k][16];
            #1;
            check($sformatf("R6 R7 R8 R9 R10 pad_out vector %0d", k), pad_out, VEC[k][15:8]);
            check($sformatf("R6 R7 R8 R9 R10 pad_oe vector %0d", k), pad_oe, VEC[k][7:0]);
        end
        xbar_en  = 8'h00;
        xbar_out = 8'h00;
        sbus_en  = 1'b0;

        // R2 and R11: byte writes land in each register and read back
        wr_byte(2'd1, 8'h3C); rd(2'd1, 1'b1, v); check("R2 R11 output mode readback", v, 8'h3C);
        wr_byte(2'd2, 8'hFF); rd(2'd2, 1'b1, v); check("R2 R11 input mode readback", v, 8'hFF);
        wr_byte(2'd3, 8'h81); rd(2'd3, 1'b0, v); check("R2 R11 skip readback", v, 8'h81);
        wr_byte(2'd0, 8'hFF); rd(2'd0, 1'b1, v); check("R2 latch byte write", v, 8'hFF);

        // R3 single-bit writes keep neighbours
        wr_bit(2'd0, 3'd3, 1'b0); rd(2'd0, 1'b1, v); check("R3 clear bit 3", v, 8'hF7);
        wr_bit(2'd0, 3'd0, 1'b0); rd(2'd0, 1'b1, v); check("R3 clear bit 0", v, 8'hF6);
        wr_bit(2'd0, 3'd3, 1'b1); rd(2'd0, 1'b1, v); check("R3 set bit 3", v, 8'hFE);
        wr_bit(2'd3, 3'd7, 1'b0); rd(2'd3, 1'b0, v); check("R3 skip bit 7 clear", v, 8'h01);

        // R4 two-edge synchronizer latency
        @(negedge clk);
        pad_in = 8'h3C;
        rd(2'd0, 1'b0, v); check("R4 pins before any edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, 1'b0, v); check("R4 pins after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, 1'b0, v); check("R4 pins after two edges", v, 8'h3C);

        // R5 read-modify-write returns latch while pins differ
        rd(2'd0, 1'b1, v); check("R5 rmw returns latch", v, 8'hFE);

        // R4 pin read while a peripheral owns the pins
        xbar_en = 8'hFF;
        pad_in  = 8'h5A;
        repeat (2) @(negedge clk);
        rd(2'd0, 1'b0, v); check("R4 pins under peripheral", v, 8'h5A);
        xbar_en = 8'h00;

        // R7 analog pins read as zero
        wr_byte(2'd2, 8'hF0);
        pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        rd(2'd0, 1'b0, v); check("R7 analog pins read zero", v, 8'hF0);

        done = 1'b1;
        finish_run();
    end

endmodule